// File: doc/BRIEF.md
# Two-Wire Slave Address and Acknowledge Engine

This block is the slave end of a two-wire serial bus. It runs on a fast system clock that oversamples the bus. It sees bus start and stop conditions and shifts in bytes with the most significant bit first. It compares each address byte against a fixed four-bit type code and three strap pins. SDA is never driven high. The block only pulls it low: for acknowledge bits, and for the zero bits of bytes it returns to the master.

After a write, each received data byte appears on `rx_data_o` for one cycle, flagged by `rx_valid_o`. After a read, the block takes one byte from `tx_data_i` at the start of each byte it sends. The master acknowledges a byte to get the next one. A missing acknowledge ends the read. A write session ended by a stop counts as a nonvolatile commit. It opens a busy window of `BUSY_CYCLES` clocks. During that window no address is acknowledged, so the master can poll until the commit is done.

An external up/down chip select takes priority over the bus. While it is low, the bus logic stays idle and SDA is released.

Top module: `ser2w_slave`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Until a start is seen, clocked bits are ignored and no acknowledge is given.
- R2: The address byte holds the type code 0101 in bits 7:4, `pin_addr_i[2:0]` in bits 3:1 and the read flag in bit 0 (1 means read). If the byte does not match, it gets no acknowledge, and every byte after it gets none either until the next start.
- R3: The block acknowledges a matching address by holding SDA low for the whole ninth SCL pulse.
- R4: In a write session, every data byte is acknowledged on its ninth pulse. `rx_valid_o` pulses for exactly one cycle, and `rx_data_o` then holds the byte, assembled most significant bit first.
- R5: In a read session, `tx_load_o` pulses while SCL is low at the start of each byte. The byte then present on `tx_data_i` is sent most significant bit first. A further byte follows whenever the master acknowledges.
- R6: After the master fails to acknowledge a read byte, SDA stays released until the next start or stop.
- R7: A write session with at least one data byte, ended by a stop, opens a busy window of `BUSY_CYCLES` clocks. In that window no address is acknowledged, whatever its read flag. A session that carried only the address does not open the window.
- R8: Once the busy window has ended, a matching address is acknowledged with either read flag.
- R9: After reset, SDA is released, and both `rx_valid_o` and `tx_load_o` are low.
- R10: While `ud_cs_n_i` is low, the block stays idle: SDA is released and the bus is ignored.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| pin_addr_i | input | 3 | Strap pins forming address bits 3:1 |
| ud_cs_n_i | input | 1 | Up/down chip select; low holds the bus logic idle |
| rx_valid_o | output | 1 | One-cycle strobe for a received write byte |
| rx_data_o | output | 8 | Received write byte |
| tx_data_i | input | 8 | Byte to send in a read session |
| tx_load_o | output | 1 | One-cycle strobe when `tx_data_i` is taken |

## Verification
The assertions assume the master changes SDA only while SCL is low, except for starts and stops. They also assume the master never issues a stop while the slave is pulling SDA low, and that the chip select does not fall in the middle of an acknowledge pulse. The bench's master model keeps to these rules. It moves SDA several system clocks after SCL falls, and it holds each SCL phase for eight clocks, longer than the synchronizer delay. Each read session ends with a missing acknowledge before the stop, so the bus is free when SDA rises.

// File: rtl/ser2w_pkg.sv
// Shared types and constants for the two-wire slave engine.
package ser2w_pkg;
    // Protocol FSM states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ACK_ADDR,
        ST_WR_BITS,
        ST_WR_END,
        ST_WR_ACK,
        ST_RD_BITS,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_WAIT_STOP
    } ser2w_state_e;

    // Device type code compared against address bits 7:4.
    localparam logic [3:0] SER2W_TYPE_ID = 4'b0101;
endpackage

// File: rtl/ser2w_sync.sv
// Multi-stage synchronizer for asynchronous bus lines.
// Assumes the inputs are open-drain wires that idle high, so every stage resets to 1.
module ser2w_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the raw wires.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= d_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '1;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ser2w_cond.sv
// Bus condition detector: start, stop and SCL edges from synchronized lines.
// Assumes its inputs are already synchronous to clk.
module ser2w_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    // Holds the previous synchronized sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_o = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
    assign rise_o  = scl_s & ~scl_q;
    assign fall_o  = ~scl_s & scl_q;
endmodule

// File: rtl/ser2w_busy.sv
// Write-commit busy timer: counts down CYCLES clocks after a load pulse.
// Assumes a new load may restart the count at any time.
module ser2w_busy #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    // Loads the window length, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load_i)    cnt <= CW'(CYCLES);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);
endmodule

// File: rtl/ser2w_slave.sv
// Two-wire slave front end: address match, acknowledge, byte receive and send,
// and a post-commit busy window that suppresses acknowledges.
// Assumes the system clock is at least 8x faster than SCL.
module ser2w_slave
    import ser2w_pkg::*;
#(
    parameter logic [3:0] TYPE_ID     = SER2W_TYPE_ID,
    parameter int         BUSY_CYCLES = 250000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] pin_addr_i,
    input  logic       ud_cs_n_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    input  logic [7:0] tx_data_i,
    output logic       tx_load_o
);
    localparam int BITS = 8;
    localparam int CNTW = $clog2(BITS);
    localparam logic [CNTW-1:0] LAST = CNTW'(BITS - 1);

    logic [1:0]      sync_q;
    logic            scl_s, sda_s;
    logic            start, stop, rise, fall;
    logic            busy, busy_go;
    ser2w_state_e    state;
    logic [BITS-1:0] shreg;
    logic [CNTW-1:0] cnt;
    logic            rd, wr_seen;
    logic            addr_hit;

    ser2w_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    ser2w_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
    );

    ser2w_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .load_i(busy_go), .busy_o(busy)
    );

    assign addr_hit = (shreg[7:1] == {TYPE_ID, pin_addr_i});

    // Protocol sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            cnt        <= '0;
            rd         <= 1'b0;
            wr_seen    <= 1'b0;
            sda_pull_o <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
            tx_load_o  <= 1'b0;
            busy_go    <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            tx_load_o  <= 1'b0;
            busy_go    <= 1'b0;
            if (!ud_cs_n_i) begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
                wr_seen    <= 1'b0;
            end else if (start) begin
                state      <= ST_ADDR;
                cnt        <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop) begin
                busy_go    <= wr_seen;
                wr_seen    <= 1'b0;
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR_BITS: begin
                        if (rise) begin
                            shreg <= {shreg[BITS-2:0], sda_s};
                            if (cnt == LAST)
                                state <= (state == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
                            else
                                cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR_END: begin
                        if (fall) begin
                            if (addr_hit && !busy) begin
                                sda_pull_o <= 1'b1;
                                rd         <= shreg[0];
                                state      <= ST_ACK_ADDR;
                            end else begin
                                state <= ST_WAIT_STOP;
                            end
                        end
                    end
                    ST_ACK_ADDR, ST_RD_NEXT: begin
                        if (fall) begin
                            cnt <= '0;
                            if (state == ST_RD_NEXT || rd) begin
                                shreg      <= tx_data_i;
                                sda_pull_o <= ~tx_data_i[BITS-1];
                                tx_load_o  <= 1'b1;
                                state      <= ST_RD_BITS;
                            end else begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_WR_BITS;
                            end
                        end
                    end
                    ST_WR_END: begin
                        if (fall) begin
                            sda_pull_o <= 1'b1;
                            rx_valid_o <= 1'b1;
                            rx_data_o  <= shreg;
                            wr_seen    <= 1'b1;
                            state      <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (fall) begin
                            sda_pull_o <= 1'b0;
                            cnt        <= '0;
                            state      <= ST_WR_BITS;
                        end
                    end
                    ST_RD_BITS: begin
                        if (fall) begin
                            if (cnt == LAST) begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_RD_ACK;
                            end else begin
                                shreg      <= {shreg[BITS-2:0], 1'b0};
                                sda_pull_o <= ~shreg[BITS-2];
                                cnt        <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (rise) state <= sda_s ? ST_WAIT_STOP : ST_RD_NEXT;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ser2w_slave_chk.sv
// Property checker for ser2w_slave, attached by bind.
// Assumes the master keeps to the bus rules listed in the brief.
module ser2w_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_pull_o,
    input logic rx_valid_o,
    input logic tx_load_o,
    input logic ud_cs_n_i,
    input logic busy
);
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ud_cs_n_i |=> !sda_pull_o); // R10

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ud_cs_n_i && (sda_pull_o != $past(sda_pull_o))) |-> !scl_s); // R11

    AST_RXV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R4

    AST_RXV_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !busy); // R7

    AST_TXLOAD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> !scl_s); // R5
endmodule

bind ser2w_slave ser2w_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
    .rx_valid_o(rx_valid_o), .tx_load_o(tx_load_o),
    .ud_cs_n_i(ud_cs_n_i), .busy(busy)
);

// File: tb/ser2w_slave_bench.sv
// Self-checking bench: a bus master model sweeps every address against
// every strap-pin value and exercises write, read, polling and chip select.
module ser2w_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_T     = 1500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       bus_sda;
    logic       sda_pull_o;
    logic [2:0] pin_addr = 3'd0;
    logic       ud_cs_n = 1'b1;
    logic       rx_valid_o, tx_load_o;
    logic [7:0] rx_data_o, tx_data;

    int checks = 0;
    int errors = 0;
    int load_cnt = 0;
    int exp_k = 0;
    int rx_n = 0;
    int drive_bad = 0;
    logic [7:0] rx_log [16];
    logic prev_pull = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign bus_sda = sda_m & ~sda_pull_o;

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 90) & 255);
    endfunction
    assign tx_data = pat(load_cnt);

    ser2w_slave #(.BUSY_CYCLES(BUSY_T)) u_ser2w_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda),
        .sda_pull_o(sda_pull_o), .pin_addr_i(pin_addr), .ud_cs_n_i(ud_cs_n),
        .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
        .tx_data_i(tx_data), .tx_load_o(tx_load_o)
    );

    // Output monitor: logs strobes and watches drive changes against SCL.
    always @(negedge clk) begin
        if (rx_valid_o) begin
            if (rx_n < 16) rx_log[rx_n] = rx_data_o;
            rx_n++;
        end
        if (tx_load_o) load_cnt++;
        if (rst_n && sda_pull_o != prev_pull && scl) drive_bad++;
        prev_pull = sda_pull_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wc(8); scl = 1'b1; wc(8);
        sda_m = 1'b0; wc(8); scl = 1'b0; wc(4);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wc(8); scl = 1'b1; wc(8); sda_m = 1'b1; wc(8);
    endtask

    task automatic m_bit(input bit b);
        sda_m = b; wc(8); scl = 1'b1; wc(8); scl = 1'b0; wc(4);
    endtask

    task automatic m_recv(output bit b);
        sda_m = 1'b1; wc(8); scl = 1'b1; wc(4); b = bus_sda; wc(4);
        scl = 1'b0; wc(4);
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) m_bit(v[i]);
        m_recv(r);
        ack = !r;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] v);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            m_recv(r);
            v[i] = r;
        end
        m_bit(!give_ack);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic [7:0] d;
        logic [7:0] wdat [4];
        wdat[0] = 8'h00; wdat[1] = 8'hFF; wdat[2] = 8'h5A; wdat[3] = 8'h81;

        wc(5);
        rst_n = 1'b1;
        wc(2);
        // R9: released after reset
        chk(sda_pull_o == 1'b0, "R9 pull", sda_pull_o, 0);
        chk(rx_valid_o == 1'b0 && tx_load_o == 1'b0, "R9 strobes",
            {rx_valid_o, tx_load_o}, 0);

        // R1: a matching byte clocked without a start gets no acknowledge
        scl = 1'b0; wc(8);
        wr_byte({4'b0101, pin_addr, 1'b0}, ack);
        chk(!ack, "R1 no start", ack, 0);
        m_stop();

        // R2 R3: sweep strap pins, address field and read flag
        for (int p = 0; p < 8; p++) begin
            pin_addr = 3'(p);
            for (int a = 0; a < 8; a++) begin
                for (int rw = 0; rw < 2; rw++) begin
                    m_start();
                    wr_byte({4'b0101, 3'(a), 1'(rw)}, ack);
                    chk(ack == (a == p), "R2 R3 address match", ack, (a == p));
                    if (ack && rw == 1) begin
                        rd_byte(1'b0, d);
                        chk(d == pat(exp_k), "R5 sweep read", d, pat(exp_k));
                        exp_k++;
                    end
                    m_stop();
                end
            end
        end

        // R2: wrong type codes, and later bytes stay unacknowledged
        pin_addr = 3'd5;
        for (int t = 0; t < 16; t++) begin
            if (t != 5) begin
                m_start();
                wr_byte({4'(t), 3'd5, 1'b0}, ack);
                chk(!ack, "R2 type code", ack, 0);
                wr_byte(8'h00, ack);
                chk(!ack, "R2 after miss", ack, 0);
                m_stop();
            end
        end

        // R4: write session with four data bytes
        rx_n = 0;
        m_start();
        wr_byte({4'b0101, 3'd5, 1'b0}, ack);
        chk(ack, "R3 write addr", ack, 1);
        for (int i = 0; i < 4; i++) begin
            wr_byte(wdat[i], ack);
            chk(ack, "R4 data ack", ack, 1);
        end
        chk(rx_n == 4, "R4 strobe count", rx_n, 4);
        for (int i = 0; i < 4; i++)
            chk(rx_log[i] == wdat[i], "R4 data value", rx_log[i], wdat[i]);
        m_stop();

        // R7: polling during the busy window, both read flags
        for (int rw = 0; rw < 2; rw++) begin
            m_start();
            wr_byte({4'b0101, 3'd5, 1'(rw)}, ack);
            chk(!ack, "R7 busy poll", ack, 0);
            m_stop();
        end
        wc(BUSY_T);

        // R8: after the window both read flags are acknowledged
        m_start();
        wr_byte({4'b0101, 3'd5, 1'b1}, ack);
        chk(ack, "R8 poll read", ack, 1);
        if (ack) begin
            rd_byte(1'b0, d);
            chk(d == pat(exp_k), "R5 poll read", d, pat(exp_k));
            exp_k++;
        end
        m_stop();
        m_start();
        wr_byte({4'b0101, 3'd5, 1'b0}, ack);
        chk(ack, "R8 poll write", ack, 1);
        m_stop();
        // R7: address-only session did not open the window
        m_start();
        wr_byte({4'b0101, 3'd5, 1'b0}, ack);
        chk(ack, "R7 no window", ack, 1);
        m_stop();

        // R5 R6: multi-byte read ending in a missing acknowledge
        m_start();
        wr_byte({4'b0101, 3'd5, 1'b1}, ack);
        chk(ack, "R3 read addr", ack, 1);
        for (int i = 0; i < 3; i++) begin
            rd_byte(i < 2, d);
            chk(d == pat(exp_k), "R5 read byte", d, pat(exp_k));
            exp_k++;
        end
        chk(load_cnt == exp_k, "R5 load count", load_cnt, exp_k);
        begin
            bit r;
            int zeros = 0;
            for (int i = 0; i < 9; i++) begin
                m_recv(r);
                if (!r) zeros++;
            end
            chk(zeros == 0, "R6 released", zeros, 0);
        end
        m_stop();

        // R10: chip select low holds the bus logic idle
        ud_cs_n = 1'b0;
        m_start();
        wr_byte({4'b0101, 3'd5, 1'b0}, ack);
        chk(!ack, "R10 cs low", ack, 0);
        chk(sda_pull_o == 1'b0, "R10 pull", sda_pull_o, 0);
        m_stop();
        ud_cs_n = 1'b1;
        m_start();
        wr_byte({4'b0101, 3'd5, 1'b0}, ack);
        chk(ack, "R10 cs high", ack, 1);
        m_stop();

        // R11: drive never changed while the master held SCL high
        chk(drive_bad == 0, "R11 drive timing", drive_bad, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule